// File: doc/BRIEF.md
# Link Bring-Up Procedure Sequencer

This block runs numbered link bring-up procedures on behalf of software. Each procedure is an ordered list of steps. Software picks a procedure by writing its number to a select register. It then polls a status register until the complete bit is set. Nothing happens in the background. Each status poll drives the current procedure forward through as many steps as are ready, then reports where it stopped. A step that reports "next" passes straight to the following step within the same poll.

Steps run in external step engines. For each step the sequencer raises a one-cycle start strobe together with the procedure number and step index. It then waits for a single result beat, which carries one of three kinds (still working, advance, done) and a 4-bit outcome code. A few table slots resolve inside the block: a stop slot and three do-nothing slots. Two slots are empty. A free-running cycle counter bounds how long a procedure may stay incomplete.

Top module: `linkproc_seq`

## Requirements
- R1: After reset the block accepts requests (`req_ready` high), `rsp_valid` and `step_start` are low, and a read of offset 4 returns 0.
- R2: A 4-byte write to offset 4 naming a populated slot selects it. The next status poll starts that procedure at step index 0, with `step_proc` equal to the number.
- R3: A 4-byte write to offset 4 with a value of 14 or above, or naming slot 2 or 3, leaves the selection unchanged. The status then reads 0x40000004 (complete, outcome 4).
- R4: A status read (4-byte read of offset 0) whose stored status has bit 30 set returns the stored word unchanged and starts no step.
- R5: A status read of an incomplete procedure starts the current step. While a result of kind "advance" (kind 1) comes back, the index increments and the next step starts at once. The final index is kept, and the next poll resumes from it.
- R6: Status words use only bit 31 (in progress), bit 30 (complete) and bits 3:0 (outcome). A "done" result (kind 2) with code c yields 0x40000000|c. A "still working" result (kind 0 or 3) yields 0x80000000.
- R7: When a poll ends without completion and more than `TIMEOUT_CYCLES` clock cycles have passed since the procedure was selected, the status becomes 0x40000002.
- R8: Slot 0 finishes with 0x40000003, and slots 1, 11 and 12 finish with 0x40000000. None of these raises `step_start`. After reset slot 0 is selected.
- R9: Selecting the procedure already running restarts it from step 0 and restarts its timeout window.
- R10: A 4-byte write to offset 0 gets an error-free response and changes neither status nor selection.
- R11: Any access whose `req_size` is not 4 responds with `rsp_err` high and data 0 and has no effect. An access to an offset other than 0 or 4 also gets `rsp_err` and reads as 0.
- R12: A 4-byte read of offset 4 returns the selected number zero-extended to 32 bits.
- R13: Requests are taken one at a time. `req_ready` is low while a poll walks steps. Every accepted request gets exactly one `rsp_valid` pulse, issued as the block becomes ready again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request |
| req_ready | output | 1 | Block idle, request is taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset |
| req_size | input | 3 | Access width in bytes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Access rejected |
| rsp_rdata | output | 32 | Read data |
| step_start | output | 1 | Start strobe for one step |
| step_proc | output | 4 | Procedure number of the step |
| step_idx | output | STEP_W | Step index within the procedure |
| step_rsp_valid | input | 1 | Step result beat |
| step_rsp_kind | input | 2 | 0/3 still working, 1 advance, 2 done |
| step_rsp_code | input | 4 | Outcome code with a done result |

## Verification
The checker watches the parts of the bus and step handshake that hold on every cycle. Status and response words never carry bits outside 31, 30 and 3:0. Wrong-size accesses are rejected in the following cycle. A start strobe lasts one cycle and never coincides with readiness. An index that follows an advance result is one higher. Responses appear only as the block turns ready. Other behaviour depends on state built up across several requests, so only the directed scenarios show it: index resumption across polls, restart on reselection, the timeout window and its restart, unsupported selections that leave the number unchanged, ignored status writes, and stored complete words returned without any step activity.

// File: rtl/linkproc_pkg.sv
package linkproc_pkg;

    localparam int NUM_SLOTS  = 14;
    localparam int SLOT_W     = $clog2(NUM_SLOTS);
    localparam int DATA_W     = 32;
    localparam int SIZE_W     = 3;
    localparam int WORD_BYTES = 4;

    localparam int OFF_STATUS = 0;
    localparam int OFF_SELECT = 4;

    localparam logic [3:0] CODE_NONE    = 4'd0;
    localparam logic [3:0] CODE_FAILED  = 4'd2;
    localparam logic [3:0] CODE_ABORTED = 4'd3;
    localparam logic [3:0] CODE_UNSUP   = 4'd4;

    typedef enum logic [1:0] {
        SLOT_EMPTY = 2'd0,
        SLOT_STOP  = 2'd1,
        SLOT_NOP   = 2'd2,
        SLOT_EXT   = 2'd3
    } slot_kind_e;

    typedef enum logic [1:0] {
        STEP_BUSY = 2'd0,
        STEP_NEXT = 2'd1,
        STEP_DONE = 2'd2,
        STEP_RSVD = 2'd3
    } step_kind_e;

    typedef struct packed {
        step_kind_e kind;
        logic [3:0] code;
    } step_res_t;

    typedef struct packed {
        logic       busy;
        logic       done;
        logic [3:0] code;
    } status_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_STEP = 2'd1,
        ST_WAIT = 2'd2
    } seq_state_e;

    function automatic slot_kind_e slot_kind(input int n);
        if (n == 0)                          return SLOT_STOP;
        if (n == 1 || n == 11 || n == 12)    return SLOT_NOP;
        if (n == 2 || n == 3)                return SLOT_EMPTY;
        if (n >= NUM_SLOTS)                  return SLOT_EMPTY;
        return SLOT_EXT;
    endfunction

    function automatic logic [DATA_W-1:0] status_word(input status_t s);
        return {s.busy, s.done, 26'd0, s.code};
    endfunction

endpackage

// File: rtl/linkproc_table.sv
module linkproc_table
    import linkproc_pkg::*;
(
    input  logic [DATA_W-1:0] sel_value,
    input  logic [SLOT_W-1:0] cur_slot,
    output logic              sel_ok,
    output slot_kind_e        cur_kind
);
    localparam int ROWS = 2 ** SLOT_W;

    slot_kind_e kinds [ROWS];

    genvar g;
    generate
        for (g = 0; g < ROWS; g++) begin : g_row
            if (g < NUM_SLOTS) begin : g_used
                assign kinds[g] = slot_kind(g);
            end else begin : g_pad
                assign kinds[g] = SLOT_EMPTY;
            end
        end
    endgenerate

    logic in_range;
    assign in_range = (sel_value < DATA_W'(NUM_SLOTS));
    assign sel_ok   = in_range && (kinds[sel_value[SLOT_W-1:0]] != SLOT_EMPTY);
    assign cur_kind = kinds[cur_slot];
endmodule

// File: rtl/linkproc_timer.sv
module linkproc_timer #(
    parameter int     TIMER_W        = 32,
    parameter longint TIMEOUT_CYCLES = 125000000
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic expired
);
    localparam logic [TIMER_W-1:0] LIMIT = TIMER_W'(TIMEOUT_CYCLES);

    logic [TIMER_W-1:0] now_q;
    logic [TIMER_W-1:0] mark_q;
    logic [TIMER_W-1:0] elapsed;

    always_ff @(posedge clk) begin
        if (rst) begin
            now_q  <= '0;
            mark_q <= '0;
        end else begin
            now_q <= now_q + 1'b1;
            if (restart) mark_q <= now_q;
        end
    end

    assign elapsed = now_q - mark_q;
    assign expired = (elapsed > LIMIT);
endmodule

// File: rtl/linkproc_seq.sv
module linkproc_seq
    import linkproc_pkg::*;
#(
    parameter int     ADDR_W         = 8,
    parameter int     STEP_W         = 4,
    parameter int     TIMER_W        = 32,
    parameter longint TIMEOUT_CYCLES = 125000000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_size,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [31:0]       rsp_rdata,
    output logic              step_start,
    output logic [3:0]        step_proc,
    output logic [STEP_W-1:0] step_idx,
    input  logic              step_rsp_valid,
    input  logic [1:0]        step_rsp_kind,
    input  logic [3:0]        step_rsp_code
);
    seq_state_e        state_q;
    status_t           status_q;
    logic [SLOT_W-1:0] slot_q;
    logic [STEP_W-1:0] idx_q;
    logic              rsp_valid_q, rsp_err_q;
    logic [DATA_W-1:0] rsp_rdata_q;

    logic       accept, size_ok, at_status, at_select;
    logic       sel_ok, expired, restart;
    slot_kind_e cur_kind;
    step_res_t  in_res, res;
    logic       fin_en;
    status_t    fin_st;

    assign accept    = req_valid && (state_q == ST_IDLE);
    assign size_ok   = (req_size == SIZE_W'(WORD_BYTES));
    assign at_status = (req_addr == ADDR_W'(OFF_STATUS));
    assign at_select = (req_addr == ADDR_W'(OFF_SELECT));
    assign restart   = accept && req_write && size_ok && at_select && sel_ok;

    linkproc_table u_table (
        .sel_value (req_wdata),
        .cur_slot  (slot_q),
        .sel_ok    (sel_ok),
        .cur_kind  (cur_kind)
    );

    linkproc_timer #(
        .TIMER_W        (TIMER_W),
        .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .expired (expired)
    );

    assign in_res.kind = step_kind_e'(step_rsp_kind);
    assign in_res.code = step_rsp_code;

    // Result of the current poll, either from an internal slot or a step engine
    always_comb begin
        res    = '{kind: STEP_DONE, code: CODE_UNSUP};
        fin_en = 1'b0;
        if (state_q == ST_STEP) begin
            case (cur_kind)
                SLOT_STOP: begin res = '{kind: STEP_DONE, code: CODE_ABORTED}; fin_en = 1'b1; end
                SLOT_NOP:  begin res = '{kind: STEP_DONE, code: CODE_NONE};    fin_en = 1'b1; end
                SLOT_EXT:  fin_en = 1'b0;
                default:   fin_en = 1'b1;
            endcase
        end else if (state_q == ST_WAIT && step_rsp_valid && in_res.kind != STEP_NEXT) begin
            res    = in_res;
            fin_en = 1'b1;
        end

        if (res.kind == STEP_DONE)
            fin_st = '{busy: 1'b0, done: 1'b1, code: res.code};
        else if (expired)
            fin_st = '{busy: 1'b0, done: 1'b1, code: CODE_FAILED};
        else
            fin_st = '{busy: 1'b1, done: 1'b0, code: CODE_NONE};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            status_q    <= '0;
            slot_q      <= '0;
            idx_q       <= '0;
            rsp_valid_q <= 1'b0;
            rsp_err_q   <= 1'b0;
            rsp_rdata_q <= '0;
        end else begin
            rsp_valid_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        rsp_err_q   <= 1'b0;
                        rsp_rdata_q <= '0;
                        if (!size_ok) begin
                            rsp_valid_q <= 1'b1;
                            rsp_err_q   <= 1'b1;
                        end else if (req_write) begin
                            rsp_valid_q <= 1'b1;
                            if (at_select) begin
                                if (sel_ok) begin
                                    status_q <= '{busy: 1'b1, done: 1'b0, code: CODE_NONE};
                                    slot_q   <= req_wdata[SLOT_W-1:0];
                                    idx_q    <= '0;
                                end else begin
                                    status_q <= '{busy: 1'b0, done: 1'b1, code: CODE_UNSUP};
                                end
                            end else if (!at_status) begin
                                rsp_err_q <= 1'b1;
                            end
                        end else if (at_select) begin
                            rsp_valid_q <= 1'b1;
                            rsp_rdata_q <= DATA_W'(slot_q);
                        end else if (at_status) begin
                            if (status_q.done) begin
                                rsp_valid_q <= 1'b1;
                                rsp_rdata_q <= status_word(status_q);
                            end else begin
                                state_q <= ST_STEP;
                            end
                        end else begin
                            rsp_valid_q <= 1'b1;
                            rsp_err_q   <= 1'b1;
                        end
                    end
                end
                ST_STEP: begin
                    if (cur_kind == SLOT_EXT) state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (step_rsp_valid && in_res.kind == STEP_NEXT) begin
                        idx_q   <= idx_q + 1'b1;
                        state_q <= ST_STEP;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase

            if (fin_en) begin
                status_q    <= fin_st;
                rsp_valid_q <= 1'b1;
                rsp_err_q   <= 1'b0;
                rsp_rdata_q <= status_word(fin_st);
                state_q     <= ST_IDLE;
            end
        end
    end

    assign req_ready  = (state_q == ST_IDLE);
    assign rsp_valid  = rsp_valid_q;
    assign rsp_err    = rsp_err_q;
    assign rsp_rdata  = rsp_rdata_q;
    assign step_start = (state_q == ST_STEP) && (cur_kind == SLOT_EXT);
    assign step_proc  = 4'(slot_q);
    assign step_idx   = idx_q;
endmodule

// File: rtl/linkproc_seq_chk.sv
module linkproc_seq_chk #(
    parameter int STEP_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [2:0]        req_size,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [31:0]       rsp_rdata,
    input logic              step_start,
    input logic [STEP_W-1:0] step_idx,
    input logic              step_rsp_valid,
    input logic [1:0]        step_rsp_kind
);
    p_status_bits_r6: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_err) |-> (rsp_rdata[29:4] == 26'd0));

    p_size_err_r11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_size != 3'd4) |=> (rsp_valid && rsp_err && rsp_rdata == 32'd0));

    p_start_busy_r13: assert property (@(posedge clk) disable iff (rst)
        step_start |-> !req_ready);

    p_rsp_ready_r13: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> req_ready);

    p_start_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        step_start |=> !step_start);

    p_idx_advance_r5: assert property (@(posedge clk) disable iff (rst)
        (step_start && $past(step_rsp_valid && step_rsp_kind == 2'd1))
            |-> (step_idx == STEP_W'($past(step_idx) + 1'b1)));
endmodule

bind linkproc_seq linkproc_seq_chk #(.STEP_W(STEP_W)) u_chk (.*);

// File: tb/linkproc_seq_test.sv
module linkproc_seq_test;
    localparam int STEP_W  = 4;
    localparam int TIMEOUT = 300;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [2:0]  req_size = 3'd4;
    logic [31:0] req_wdata = '0;
    logic        req_ready, rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic        step_start;
    logic [3:0]  step_proc;
    logic [STEP_W-1:0] step_idx;
    logic        step_rsp_valid = 1'b0;
    logic [1:0]  step_rsp_kind = '0;
    logic [3:0]  step_rsp_code = '0;

    int checks = 0;
    int errors = 0;
    int starts = 0;
    int overlap = 0;
    int first_idx = -1;
    int last_idx = -1;
    int last_proc = -1;
    bit done_flag = 0;

    always #4 clk = ~clk;

    linkproc_seq #(.STEP_W(STEP_W), .TIMEOUT_CYCLES(TIMEOUT)) uut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Scripted step engines: kind 0 busy, 1 advance, 2 done
    function automatic logic [5:0] script(input int p, input int i);
        case (p)
            4:  return (i == 0) ? {2'd1, 4'd0} : {2'd0, 4'd0};
            5:  return {2'd0, 4'd0};
            6:  return (i < 2) ? {2'd1, 4'd0} : {2'd2, 4'd2};
            13: return {2'd2, 4'd0};
            default: return {2'd2, 4'hF};
        endcase
    endfunction

    initial begin : responder
        bit pend = 0;
        logic [5:0] r = '0;
        forever begin
            @(negedge clk);
            if (pend) begin
                step_rsp_valid = 1'b1;
                {step_rsp_kind, step_rsp_code} = r;
                pend = 0;
            end else begin
                step_rsp_valid = 1'b0;
            end
            if (step_start) begin
                starts++;
                if (req_ready) overlap++;
                if (first_idx < 0) first_idx = int'(step_idx);
                last_idx  = int'(step_idx);
                last_proc = int'(step_proc);
                r = script(int'(step_proc), int'(step_idx));
                pend = 1;
            end
        end
    end

    task automatic clear_log();
        starts = 0; first_idx = -1; last_idx = -1; last_proc = -1;
    endtask

    task automatic bus(input bit w, input logic [7:0] a, input logic [2:0] sz,
                       input logic [31:0] d, output logic [31:0] q, output logic e);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_size = sz; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        for (int n = 0; n < 2000 && !rsp_valid; n++) @(negedge clk);
        q = rsp_rdata;
        e = rsp_err;
    endtask

    task automatic sel(input logic [31:0] n);
        logic [31:0] q; logic e;
        bus(1'b1, 8'd4, 3'd4, n, q, e);
    endtask

    task automatic poll(output logic [31:0] q);
        logic e;
        bus(1'b0, 8'd0, 3'd4, 32'd0, q, e);
    endtask

    task automatic t_reset();
        logic [31:0] q; logic e;
        chk("R1 ready", {31'd0, req_ready}, 32'd1);
        chk("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
        chk("R1 step_start", {31'd0, step_start}, 32'd0);
        bus(1'b0, 8'd4, 3'd4, 32'd0, q, e);
        chk("R1 select after reset", q, 32'd0);
        @(negedge clk);
        chk("R13 single response pulse", {31'd0, rsp_valid}, 32'd0);
        clear_log();
        poll(q);
        chk("R8 stop slot status", q, 32'h4000_0003);
        chk("R8 stop slot no step", starts, 0);
    endtask

    task automatic t_internal_slots();
        logic [31:0] q;
        clear_log();
        sel(1);  poll(q); chk("R8 slot 1", q, 32'h4000_0000);
        sel(11); poll(q); chk("R8 slot 11", q, 32'h4000_0000);
        sel(12); poll(q); chk("R8 slot 12", q, 32'h4000_0000);
        chk("R8 no step for internal slots", starts, 0);
        sel(0);  poll(q); chk("R8 reselect stop", q, 32'h4000_0003);
    endtask

    task automatic t_chain();
        logic [31:0] q;
        sel(6); clear_log();
        poll(q);
        chk("R5 chained outcome", q, 32'h4000_0002);
        chk("R5 steps started", starts, 3);
        chk("R2 first index", first_idx, 0);
        chk("R5 last index", last_idx, 2);
        chk("R2 step proc", last_proc, 6);
        clear_log();
        poll(q);
        chk("R4 stored complete", q, 32'h4000_0002);
        chk("R4 no step on complete", starts, 0);
    endtask

    task automatic t_done_and_select();
        logic [31:0] q; logic e;
        sel(13); poll(q);
        chk("R6 done code", q, 32'h4000_0000);
        bus(1'b0, 8'd4, 3'd4, 32'd0, q, e);
        chk("R12 select read", q, 32'd13);
        chk("R12 no error", {31'd0, e}, 32'd0);
    endtask

    task automatic t_status_write();
        logic [31:0] q; logic e;
        bus(1'b1, 8'd0, 3'd4, 32'hFFFF_FFFF, q, e);
        chk("R10 write ok", {31'd0, e}, 32'd0);
        clear_log();
        poll(q);
        chk("R10 status unchanged", q, 32'h4000_0000);
        chk("R10 no step", starts, 0);
    endtask

    task automatic t_bad_access();
        logic [31:0] q; logic e;
        bus(1'b1, 8'd4, 3'd2, 32'd5, q, e);
        chk("R11 short write err", {31'd0, e}, 32'd1);
        bus(1'b0, 8'd4, 3'd4, 32'd0, q, e);
        chk("R11 short write no effect", q, 32'd13);
        bus(1'b0, 8'd0, 3'd1, 32'd0, q, e);
        chk("R11 short read err", {31'd0, e}, 32'd1);
        chk("R11 short read data", q, 32'd0);
        bus(1'b0, 8'd8, 3'd4, 32'd0, q, e);
        chk("R11 bad offset err", {31'd0, e}, 32'd1);
        chk("R11 bad offset data", q, 32'd0);
    endtask

    task automatic t_unsupported();
        logic [31:0] q; logic e;
        logic [31:0] bad [3] = '{32'd14, 32'd2, 32'hFFFF_FFFF};
        for (int k = 0; k < 3; k++) begin
            sel(13); poll(q);
            clear_log();
            sel(bad[k]);
            poll(q);
            chk("R3 unsupported status", q, 32'h4000_0004);
            chk("R3 no step", starts, 0);
            bus(1'b0, 8'd4, 3'd4, 32'd0, q, e);
            chk("R3 selection kept", q, 32'd13);
        end
    endtask

    task automatic t_resume_restart();
        logic [31:0] q;
        sel(4); clear_log();
        poll(q);
        chk("R6 busy status", q, 32'h8000_0000);
        chk("R5 advanced once", starts, 2);
        chk("R5 stopped at index", last_idx, 1);
        clear_log();
        poll(q);
        chk("R5 resumes at saved index", first_idx, 1);
        chk("R13 never ready during step", overlap, 0);
        sel(4); clear_log();
        poll(q);
        chk("R9 restart at index 0", first_idx, 0);
    endtask

    task automatic t_timeout();
        logic [31:0] q;
        sel(5); poll(q);
        chk("R7 before limit", q, 32'h8000_0000);
        repeat (TIMEOUT + 50) @(negedge clk);
        poll(q);
        chk("R7 timed out", q, 32'h4000_0002);
        clear_log();
        poll(q);
        chk("R4 timeout kept", q, 32'h4000_0002);
        chk("R4 no step after timeout", starts, 0);
        sel(5); poll(q);
        repeat (200) @(negedge clk);
        sel(5);
        repeat (200) @(negedge clk);
        poll(q);
        chk("R9 window restarted", q, 32'h8000_0000);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_internal_slots();
        t_chain();
        t_done_and_select();
        t_status_write();
        t_bad_access();
        t_unsupported();
        t_resume_restart();
        t_timeout();
        finish_run();
    end
endmodule